// File: doc/BRIEF.md
# Full-Array Erase and Blank-Check Sequencer

This controller performs a complete erase of an external byte-wide, electrically erasable memory array. It is started by a one-cycle host request. It first preconditions the array by writing 00h to every location, one location at a time, using a timed program strobe. It then applies a long erase pulse, with both the program-supply enable and the address-bit-9 high-voltage enable raised. After a recovery gap and a short setup interval, it reads the array back from address 0 upward and requires every byte to read FFh.

When the blank check meets a byte other than FFh, it abandons the scan and applies another erase pulse. A limit bounds the number of erase pulses. The host sees a busy flag and a running count of erase pulses. It also sees a pass or a fail result, which stays valid until the next start. The analog supplies are outside this block: it only drives the enables that switch them.

The state machine has seven states. IDLE waits for start. PRG holds the program strobe. PGAP is a one-cycle gap that either steps to the next address or, after the last one, enters ERS. ERS holds the erase pulse. RCV is the recovery gap. VSET is the read setup interval. VRD compares one byte per cycle.

The transitions are as follows:
- IDLE→PRG on start.
- PRG→PGAP when the strobe time expires.
- PGAP→PRG on a next address.
- PGAP→ERS after the last address.
- ERS→RCV and RCV→VSET when their timers expire.
- VSET→VRD when the setup timer expires.
- VRD stays in VRD while bytes are blank and addresses remain.
- VRD→ERS on a non-blank byte below the limit.
- VRD→IDLE with pass after the last address.
- VRD→IDLE with fail on a non-blank byte at the limit.

Top module: `erase_seq`

## Requirements
- R1: After reset, busy, pass and fail are 0 and iter_count is 0. mem_ce_n and mem_oe_n are 1, and vpp_en and a9hv_en are 0.
- R2: After start, every address from 0 to 2^ADDR_W-1 is programmed in ascending order. Each address gets mem_wdata = 00h, vpp_en = 1 and mem_oe_n = 1, with mem_ce_n low for exactly PROG_CYC cycles. Each strobe is followed by at least one cycle with mem_ce_n high. The first erase pulse begins only after the last address has been programmed.
- R3: Each erase pulse holds vpp_en = 1 and a9hv_en = 1 for exactly ERASE_CYC cycles, with mem_ce_n = 1 and mem_oe_n = 1.
- R4: After every erase pulse, all enables stay deasserted (mem_ce_n = 1, vpp_en = 0) for exactly RECOV_CYC cycles. The read setup then holds mem_ce_n = 0, mem_oe_n = 0 and vpp_en = 0 for VSET_CYC cycles before the first compare. vpp_en is never 1 while mem_oe_n is 0.
- R5: The blank check compares one byte per cycle, from address 0 upward, against FFh. It stops at the first address that is not FFh, so the highest address presented in that read window is the failing address. A fully blank array is read up to address 2^ADDR_W-1.
- R6: iter_count equals the number of erase pulses applied since the last start. A failing blank check with iter_count below MAX_ITER leads directly to another erase pulse.
- R7: A failing blank check with iter_count equal to MAX_ITER ends the run with fail = 1, after exactly MAX_ITER erase pulses.
- R8: pass and fail are never both 1. The result holds unchanged while idle and is cleared in the cycle after a start is accepted.
- R9: A start request while busy = 1 has no effect: the run continues, and no address is programmed a second time.
- R10: busy is 1 from the cycle after an accepted start until the cycle in which pass or fail rises, where it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an erase run |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run ended with a blank array |
| fail | output | 1 | Last run reached the pulse limit without a blank array |
| iter_count | output | $clog2(MAX_ITER+1) | Erase pulses applied in the current or last run |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | DATA_W | Write data (00h during preconditioning, FFh otherwise) |
| mem_rdata | input | DATA_W | Read data from the array |
| mem_ce_n | output | 1 | Active-low chip enable / program strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| vpp_en | output | 1 | Program-supply enable |
| a9hv_en | output | 1 | Address-bit-9 high-voltage enable |

## Verification
The bench builds the block with ADDR_W = 4, PROG_CYC = 3, ERASE_CYC = 20, RECOV_CYC = 5 and VSET_CYC = 2. These short values make every strobe, pulse and gap length exactly countable. MAX_ITER keeps its default of 200, so both the pass on the 200th pulse and the fail after the 200th pulse lie within reach of a short run. A behavioural array model keeps one chosen address stuck at 00h until a chosen number of pulses has been applied. This lets the table of cases place the first non-blank byte at address 0, in the middle, or at the last address, and observe where each scan stops.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PRG,
        S_PGAP,
        S_ERS,
        S_RCV,
        S_VSET,
        S_VRD
    } seq_state_t;
endpackage

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/erase_seq_addr.sv
module erase_seq_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

    assign last = (addr == {ADDR_W{1'b1}});
endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int PROG_CYC  = 1250,
    parameter int ERASE_CYC = 25_000_000,
    parameter int RECOV_CYC = 25_000_000,
    parameter int VSET_CYC  = 100,
    parameter int MAX_ITER  = 200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          busy,
    output logic                          pass,
    output logic                          fail,
    output logic [$clog2(MAX_ITER+1)-1:0] iter_count,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          mem_ce_n,
    output logic                          mem_oe_n,
    output logic                          vpp_en,
    output logic                          a9hv_en
);
    localparam int IW   = $clog2(MAX_ITER + 1);
    localparam int M_A  = (PROG_CYC > VSET_CYC) ? PROG_CYC : VSET_CYC;
    localparam int M_B  = (ERASE_CYC > RECOV_CYC) ? ERASE_CYC : RECOV_CYC;
    localparam int MAXC = (M_A > M_B) ? M_A : M_B;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] T_PROG = TW'(PROG_CYC - 1);
    localparam logic [TW-1:0] T_ERS  = TW'(ERASE_CYC - 1);
    localparam logic [TW-1:0] T_RCV  = TW'(RECOV_CYC - 1);
    localparam logic [TW-1:0] T_VSET = TW'(VSET_CYC - 1);
    localparam logic [IW-1:0] ITER_LIM = IW'(MAX_ITER);

    seq_state_t st_q, st_d;
    logic [IW-1:0] iter_q;
    logic pass_q, fail_q;

    logic          t_load, t_done;
    logic [TW-1:0] t_val;
    logic          a_clr, a_inc, a_last;
    logic          it_clr, it_inc, set_pass, set_fail, clr_res;

    erase_seq_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    erase_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc),
        .addr(mem_addr), .last(a_last)
    );

    // next-state and datapath strobes
    always_comb begin
        st_d     = st_q;
        t_load   = 1'b0;
        t_val    = '0;
        a_clr    = 1'b0;
        a_inc    = 1'b0;
        it_clr   = 1'b0;
        it_inc   = 1'b0;
        set_pass = 1'b0;
        set_fail = 1'b0;
        clr_res  = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (start) begin
                    st_d    = S_PRG;
                    t_load  = 1'b1;
                    t_val   = T_PROG;
                    a_clr   = 1'b1;
                    it_clr  = 1'b1;
                    clr_res = 1'b1;
                end
            end
            S_PRG: begin
                if (t_done) st_d = S_PGAP;
            end
            S_PGAP: begin
                t_load = 1'b1;
                if (a_last) begin
                    st_d   = S_ERS;
                    t_val  = T_ERS;
                    it_inc = 1'b1;
                end else begin
                    st_d  = S_PRG;
                    t_val = T_PROG;
                    a_inc = 1'b1;
                end
            end
            S_ERS: begin
                if (t_done) begin
                    st_d   = S_RCV;
                    t_load = 1'b1;
                    t_val  = T_RCV;
                end
            end
            S_RCV: begin
                if (t_done) begin
                    st_d   = S_VSET;
                    t_load = 1'b1;
                    t_val  = T_VSET;
                    a_clr  = 1'b1;
                end
            end
            S_VSET: begin
                if (t_done) st_d = S_VRD;
            end
            S_VRD: begin
                if (mem_rdata != {DATA_W{1'b1}}) begin
                    if (iter_q == ITER_LIM) begin
                        st_d     = S_IDLE;
                        set_fail = 1'b1;
                    end else begin
                        st_d   = S_ERS;
                        t_load = 1'b1;
                        t_val  = T_ERS;
                        it_inc = 1'b1;
                    end
                end else if (a_last) begin
                    st_d     = S_IDLE;
                    set_pass = 1'b1;
                end else begin
                    a_inc = 1'b1;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // state register and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            iter_q <= '0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (it_clr)      iter_q <= '0;
            else if (it_inc) iter_q <= iter_q + 1'b1;
            if (clr_res) begin
                pass_q <= 1'b0;
                fail_q <= 1'b0;
            end else begin
                if (set_pass) pass_q <= 1'b1;
                if (set_fail) fail_q <= 1'b1;
            end
        end
    end

    // device and host outputs from state
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        vpp_en    = 1'b0;
        a9hv_en   = 1'b0;
        mem_wdata = {DATA_W{1'b1}};
        unique case (st_q)
            S_PRG: begin
                mem_ce_n  = 1'b0;
                vpp_en    = 1'b1;
                mem_wdata = '0;
            end
            S_PGAP: begin
                vpp_en    = 1'b1;
                mem_wdata = '0;
            end
            S_ERS: begin
                vpp_en  = 1'b1;
                a9hv_en = 1'b1;
            end
            S_VSET, S_VRD: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign busy       = (st_q != S_IDLE);
    assign pass       = pass_q;
    assign fail       = fail_q;
    assign iter_count = iter_q;

    // first erase pulse follows the strobe at the last address
    assert_precond_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(a9hv_en) && iter_q == IW'(1)) |-> ($past(mem_addr) == {ADDR_W{1'b1}}));

    // end of pulse leads into a gap with all enables off
    assert_recov_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a9hv_en) |-> (mem_ce_n && mem_oe_n && !vpp_en));

    // pulse count only steps by one or restarts
    assert_iter_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_q != $past(iter_q)) |-> ((iter_q == $past(iter_q) + 1'b1) || (iter_q == '0)));

    assert_iter_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iter_q <= ITER_LIM);

    assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_q && fail_q));

    assert_done_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pass_q) || $rose(fail_q)) |-> (!busy && $past(busy)));
endmodule

// File: tb/tb_erase_seq.sv
module tb_erase_seq;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int PROG_CYC  = 3;
    localparam int ERASE_CYC = 20;
    localparam int RECOV_CYC = 5;
    localparam int VSET_CYC  = 2;
    localparam int MAX_ITER  = 200;
    localparam int IW        = $clog2(MAX_ITER + 1);
    localparam int DEPTH     = 1 << ADDR_W;

    localparam int NV = 7;
    localparam int V_NEED [NV] = '{1, 3, 7, 4, 2, 200, 201};
    localparam int V_STUCK[NV] = '{5, 5, 0, 15, 9, 2, 2};
    localparam int V_PASS [NV] = '{1, 1, 1, 1, 1, 1, 0};
    localparam int V_ITER [NV] = '{1, 3, 7, 4, 2, 200, 200};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, pass, fail, ce_n, oe_n, vpp_en, a9hv_en;
    logic [IW-1:0] iter_count;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rdata;

    always #10 clk = ~clk;

    erase_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .RECOV_CYC(RECOV_CYC), .VSET_CYC(VSET_CYC), .MAX_ITER(MAX_ITER)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .pass(pass), .fail(fail),
        .iter_count(iter_count), .mem_addr(addr), .mem_wdata(wdata), .mem_rdata(rdata),
        .mem_ce_n(ce_n), .mem_oe_n(oe_n), .vpp_en(vpp_en), .a9hv_en(a9hv_en)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // array model and monitor state
    logic [DATA_W-1:0] mem [DEPTH];
    int need_v = 1;
    int stuck_v = 0;
    int epulses, nprog, erun, prun, rcv;
    int err_prog, err_ers, err_rcv, err_pre, err_scan, err_excl;
    bit in_prog, in_rcv, in_vfy, have_win, prev_a9;
    logic [ADDR_W-1:0] next_prog, vmax, win_max;

    assign rdata = (!ce_n && !oe_n && !vpp_en) ? mem[addr] : 8'h3C;

    always @(negedge clk) begin
        if (start && !busy) begin
            for (int i = 0; i < DEPTH; i++) mem[i] = 8'hA5;
            epulses = 0; nprog = 0; erun = 0; prun = 0; rcv = 0;
            err_prog = 0; err_ers = 0; err_rcv = 0; err_pre = 0; err_scan = 0;
            in_prog = 0; in_rcv = 0; in_vfy = 0; have_win = 0;
            next_prog = '0; vmax = '0; win_max = '0;
        end
        if (pass && fail) err_excl++;
        // programming strobes
        if (!ce_n && vpp_en && !a9hv_en) begin
            if (!in_prog) begin
                in_prog = 1;
                prun = 0;
                if (addr != next_prog) err_prog++;
                next_prog = next_prog + 1'b1;
            end
            prun++;
            if (!oe_n || wdata != 8'h00) err_prog++;
            mem[addr] = mem[addr] & wdata;
        end else if (in_prog) begin
            in_prog = 0;
            nprog++;
            if (prun != PROG_CYC) err_prog++;
        end
        // verify read window
        if (!ce_n && !oe_n) begin
            if (vpp_en) err_rcv++;
            if (!in_vfy) begin
                in_vfy = 1;
                vmax = '0;
            end
            if (addr > vmax) vmax = addr;
        end else if (in_vfy) begin
            in_vfy = 0;
            win_max = vmax;
            have_win = 1;
        end
        // erase pulse start
        if (a9hv_en && !prev_a9) begin
            erun = 0;
            if (epulses == 0) begin
                if (nprog != DEPTH) err_pre++;
                for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'h00) err_pre++;
            end
            if (have_win) begin
                if (int'(win_max) != stuck_v) err_scan++;
                have_win = 0;
            end
        end
        if (a9hv_en) begin
            erun++;
            if (!vpp_en || !ce_n || !oe_n) err_ers++;
        end
        // erase pulse end: apply erase to the model
        if (!a9hv_en && prev_a9) begin
            if (erun != ERASE_CYC) err_ers++;
            epulses++;
            for (int i = 0; i < DEPTH; i++)
                mem[i] = (epulses < need_v && i == stuck_v) ? 8'h00 : 8'hFF;
            in_rcv = 1;
            rcv = 0;
        end
        if (in_rcv) begin
            if (ce_n && !vpp_en) rcv++;
            else begin
                if (rcv != RECOV_CYC) err_rcv++;
                in_rcv = 0;
            end
        end
        prev_a9 = a9hv_en;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(posedge clk); #5 start = 1'b1;
        @(posedge clk); #5 start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 30000) begin
            @(negedge clk);
            n++;
        end
        #1;
    endtask

    task automatic run_row(input int need, input int stuck, input int exp_pass, input int exp_iter,
                           input bit mid_start);
        need_v = need;
        stuck_v = stuck;
        pulse_start();
        @(negedge clk); #1;
        check("R10", "busy after start", int'(busy), 1);
        check("R8", "result cleared", int'(pass) + int'(fail), 0);
        if (mid_start) begin
            repeat (40) @(posedge clk);
            pulse_start();
        end
        wait_idle();
        check("R10", "busy at end", int'(busy), 0);
        check("R7", "pass", int'(pass), exp_pass);
        check("R7", "fail", int'(fail), 1 - exp_pass);
        check("R6", "iter_count", int'(iter_count), exp_iter);
        check("R6", "erase pulses seen", epulses, exp_iter);
        check("R2", "bytes programmed", nprog, DEPTH);
        check("R2", "program strobe errors", err_prog, 0);
        check("R2", "precondition errors", err_pre, 0);
        check("R3", "erase pulse errors", err_ers, 0);
        check("R4", "recovery errors", err_rcv, 0);
        check("R5", "scan stop errors", err_scan, 0);
        check("R5", "last window top address", int'(win_max), exp_pass ? DEPTH - 1 : stuck);
        check("R8", "exclusive results", err_excl, 0);
    endtask

    initial begin
        #1;
        check("R1", "busy in reset", int'(busy), 0);
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", "busy", int'(busy), 0);
        check("R1", "pass|fail", int'(pass) + int'(fail), 0);
        check("R1", "iter_count", int'(iter_count), 0);
        check("R1", "ce_n&oe_n", int'(ce_n & oe_n), 1);
        check("R1", "vpp|a9hv", int'(vpp_en | a9hv_en), 0);

        for (int v = 0; v < NV; v++)
            run_row(V_NEED[v], V_STUCK[v], V_PASS[v], V_ITER[v], 1'b0);

        // result held while idle after a failing run
        repeat (50) @(posedge clk);
        @(negedge clk); #1;
        check("R8", "fail held", int'(fail), 1);
        check("R8", "pass held low", int'(pass), 0);
        check("R8", "iter held", int'(iter_count), MAX_ITER);

        // start while busy is ignored
        run_row(3, 7, 1, 3, 1'b1);
        check("R9", "no reprogramming", nprog, DEPTH);
        check("R9", "pulse count unchanged", epulses, 3);

        // pass held, then cleared by the next start
        repeat (30) @(posedge clk);
        @(negedge clk); #1;
        check("R8", "pass held", int'(pass), 1);
        run_row(1, 0, 1, 1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired busy=%0d expected=0", busy);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule